// File: doc/BRIEF.md
# Interrupt Mask and Priority Arbiter

This block keeps the two interrupt mask bits of a small 8-bit CPU's condition code register and decides which interrupt the instruction sequencer takes next. The `x_mask` bit gates a high-priority, active-low request line. Once software has cleared it, it can never set it again, so that line becomes truly unmaskable. The `i_mask` bit gates a group of ordinary requests that have a fixed priority among themselves. An illegal-opcode trap request ignores both masks.

The sequencer marks each instruction boundary with a strobe. Arbitration happens only on that strobe. The winner is latched and held until the sequencer reports that the condition code register has been stacked (`entry_done`). At that point the masks are raised for the interrupt being entered. A return-from-interrupt pulse loads both masks from the unstacked condition code byte.

The controller has two states. In `ST_RUN` it waits for an instruction boundary that has an eligible request; when one arrives it takes the transition *select* to `ST_PEND`. `ST_PEND` drives the held selection to the outputs. The transition *enter* returns it to `ST_RUN` when `entry_done` is seen. The `nmi_n` line passes through a two-flop synchronizer before the arbiter sees it.

Top module: `irq_mask_arb`

## Requirements
- R1: While reset is active and in the first cycle after it, `x_mask` = 1, `i_mask` = 1 and `int_valid` = 0.
- R2: A write (`ccr_wr`) loads `i_mask` from `ccr_i` and may clear `x_mask` (`ccr_x` = 0). A write with `ccr_x` = 1 while `x_mask` = 0 leaves `x_mask` at 0.
- R3: `nmi_n` is active low and passes through two flops. A low level first becomes eligible at the third rising edge after it is applied. It is eligible only when `x_mask` = 0, and `i_mask` has no effect on it.
- R4: Priority is trap > nmi > maskable. Among the maskable lines, the lowest set index of `irq_req` wins. `int_kind` is encoded as 0 = none, 1 = trap, 2 = nmi, 3 = maskable. `int_idx` gives the winning maskable index and is 0 for the other kinds.
- R5: Maskable requests are eligible only when `i_mask` = 0.
- R6: In `ST_RUN`, a `boundary` with an eligible request moves the block to `ST_PEND` on that edge (`int_valid` = 1). In `ST_PEND` the selection is held, and further `boundary` strobes are ignored until `entry_done`.
- R7: `entry_done` in `ST_PEND` for a maskable or trap interrupt sets `i_mask`, leaves `x_mask` unchanged, and clears `int_valid`.
- R8: `entry_done` in `ST_PEND` for the nmi sets both `x_mask` and `i_mask`.
- R9: `rti` loads `x_mask` from `rti_x` and `i_mask` from `rti_i`. This load may set `x_mask`.
- R10: A `trap_req` at a `boundary` in `ST_RUN` is selected whatever the values of `x_mask` and `i_mask`.
- R11: If several mask updates arrive in the same cycle, entry in `ST_PEND` takes precedence over `rti`, and `rti` takes precedence over `ccr_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ccr_wr | input | 1 | Software write strobe for the mask bits |
| ccr_x | input | 1 | New X value for a write (it can only clear) |
| ccr_i | input | 1 | New I value for a write |
| nmi_n | input | 1 | Unmaskable request, active low, asynchronous level |
| trap_req | input | 1 | Illegal-opcode trap request |
| irq_req | input | N_SRC | Maskable requests, index 0 has the highest priority |
| boundary | input | 1 | Instruction boundary strobe |
| entry_done | input | 1 | CCR stacked and interrupt entered |
| rti | input | 1 | Return-from-interrupt pulse |
| rti_x | input | 1 | X bit taken from the unstacked CCR |
| rti_i | input | 1 | I bit taken from the unstacked CCR |
| int_valid | output | 1 | A selected interrupt is pending |
| int_kind | output | 2 | Kind of the selected interrupt |
| int_idx | output | $clog2(N_SRC) | Index of the winning maskable source |
| x_mask | output | 1 | Live X mask bit |
| i_mask | output | 1 | Live I mask bit |

## Verification
The bench uses the default `N_SRC` = 8 and `SYNC_DEPTH` = 2. With these values the maskable index is 3 bits wide, and the directed cases reach both the lowest and the highest source positions. The model also reproduces the two-edge delay of the nmi line, so the cycle in which the nmi first becomes visible is checked exactly. This includes boundaries that arrive before it is visible. A random phase mixes boundaries, entries, returns and software writes in the same cycles. That mix exercises the update precedence and the one-way X rule against the reference model on every clock.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_TRAP = 2'b01,
        KIND_NMI  = 2'b10,
        KIND_IRQ  = 2'b11
    } int_kind_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_nmi_sync.sv
module irq_nmi_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    output logic nmi_lvl
);
    logic [DEPTH-1:0] chain;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= nmi_n;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= 1'b1;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign nmi_lvl = ~chain[DEPTH-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 8,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int b = N_SRC - 1; b >= 0; b--) begin
            if (req[b]) idx = IDX_W'(b);
        end
    end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic take_nmi,
    input  logic rti,
    input  logic rti_x,
    input  logic rti_i,
    input  logic wr,
    input  logic wr_x,
    input  logic wr_i,
    output logic x_q,
    output logic i_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= 1'b1;
            i_q <= 1'b1;
        end else if (take) begin
            i_q <= 1'b1;
            if (take_nmi) x_q <= 1'b1;
        end else if (rti) begin
            x_q <= rti_x;
            i_q <= rti_i;
        end else if (wr) begin
            x_q <= x_q & wr_x;
            i_q <= wr_i;
        end
    end
endmodule

// File: rtl/irq_mask_arb.sv
module irq_mask_arb
    import irq_arb_pkg::*;
#(
    parameter int N_SRC      = 8,
    parameter int SYNC_DEPTH = 2,
    localparam int IDX_W     = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ccr_wr,
    input  logic             ccr_x,
    input  logic             ccr_i,
    input  logic             nmi_n,
    input  logic             trap_req,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             boundary,
    input  logic             entry_done,
    input  logic             rti,
    input  logic             rti_x,
    input  logic             rti_i,
    output logic             int_valid,
    output logic [1:0]       int_kind,
    output logic [IDX_W-1:0] int_idx,
    output logic             x_mask,
    output logic             i_mask
);
    arb_state_e       state_q, state_nx;
    int_kind_e        sel_kind_q, cand_kind;
    logic [IDX_W-1:0] sel_idx_q, cand_idx, enc_idx;
    logic             nmi_lvl, irq_any, take, select;
    logic             x_q, i_q;

    irq_nmi_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .nmi_lvl(nmi_lvl)
    );

    irq_prio_enc #(.N_SRC(N_SRC), .IDX_W(IDX_W)) enc_i (
        .req(irq_req), .any(irq_any), .idx(enc_idx)
    );

    irq_mask_regs masks_i (
        .clk(clk), .rst_n(rst_n),
        .take(take), .take_nmi(sel_kind_q == KIND_NMI),
        .rti(rti), .rti_x(rti_x), .rti_i(rti_i),
        .wr(ccr_wr), .wr_x(ccr_x), .wr_i(ccr_i),
        .x_q(x_q), .i_q(i_q)
    );

    // candidate choice at the current boundary
    always_comb begin
        cand_kind = KIND_NONE;
        cand_idx  = '0;
        if (trap_req) begin
            cand_kind = KIND_TRAP;
        end else if (nmi_lvl && !x_q) begin
            cand_kind = KIND_NMI;
        end else if (irq_any && !i_q) begin
            cand_kind = KIND_IRQ;
            cand_idx  = enc_idx;
        end
    end

    assign select = (state_q == ST_RUN) && boundary && (cand_kind != KIND_NONE);
    assign take   = (state_q == ST_PEND) && entry_done;

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN:  if (select) state_nx = ST_PEND;
            ST_PEND: if (entry_done) state_nx = ST_RUN;
        endcase
    end

    // state and held selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            sel_kind_q <= KIND_NONE;
            sel_idx_q  <= '0;
        end else begin
            state_q <= state_nx;
            if (select) begin
                sel_kind_q <= cand_kind;
                sel_idx_q  <= cand_idx;
            end else if (take) begin
                sel_kind_q <= KIND_NONE;
                sel_idx_q  <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        int_valid = (state_q == ST_PEND);
        int_kind  = sel_kind_q;
        int_idx   = sel_idx_q;
        x_mask    = x_q;
        i_mask    = i_q;
    end
endmodule

// File: rtl/irq_mask_arb_chk.sv
module irq_mask_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             boundary,
    input logic             trap_req,
    input logic             entry_done,
    input logic             rti,
    input logic             rti_x,
    input logic             rti_i,
    input logic             nmi_lvl,
    input logic             int_valid,
    input logic [1:0]       int_kind,
    input logic [IDX_W-1:0] int_idx,
    input logic             x_mask,
    input logic             i_mask
);
    p_reset_masks_r1: assert property (@(posedge clk)
        !rst_n |=> (x_mask && i_mask && !int_valid));

    p_x_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_mask && !rti && !(int_valid && entry_done && int_kind == KIND_NMI)) |=> !x_mask);

    p_nmi_ignores_i_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_valid && boundary && !trap_req && nmi_lvl && !x_mask)
        |=> (int_valid && int_kind == KIND_NMI));

    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_valid && boundary && !trap_req && !(nmi_lvl && !x_mask) && i_mask)
        |=> !int_valid);

    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && !entry_done)
        |=> (int_valid && $stable(int_kind) && $stable(int_idx)));

    p_entry_keep_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && entry_done && int_kind != KIND_NMI)
        |=> (i_mask && !int_valid && x_mask == $past(x_mask)));

    p_entry_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid && entry_done && int_kind == KIND_NMI) |=> (x_mask && i_mask));

    p_rti_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !(int_valid && entry_done))
        |=> (x_mask == $past(rti_x) && i_mask == $past(rti_i)));

    p_trap_unmasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_valid && boundary && trap_req) |=> (int_valid && int_kind == KIND_TRAP));
endmodule

bind irq_mask_arb irq_mask_arb_chk #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .trap_req(trap_req),
    .entry_done(entry_done), .rti(rti), .rti_x(rti_x), .rti_i(rti_i),
    .nmi_lvl(nmi_lvl), .int_valid(int_valid), .int_kind(int_kind),
    .int_idx(int_idx), .x_mask(x_mask), .i_mask(i_mask)
);

// File: tb/irq_mask_arb_tb_top.sv
module irq_mask_arb_tb_top;
    localparam int N = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ccr_wr = 0, ccr_x = 0, ccr_i = 0, nmi_n = 1, trap_req = 0;
    logic [N-1:0] irq_req = '0;
    logic boundary = 0, entry_done = 0, rti = 0, rti_x = 0, rti_i = 0;
    logic int_valid, x_mask, i_mask;
    logic [1:0] int_kind;
    logic [2:0] int_idx;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_req = "R6";

    always #2.5 clk = ~clk;

    irq_mask_arb dut_i (
        .clk(clk), .rst_n(rst_n), .ccr_wr(ccr_wr), .ccr_x(ccr_x), .ccr_i(ccr_i),
        .nmi_n(nmi_n), .trap_req(trap_req), .irq_req(irq_req), .boundary(boundary),
        .entry_done(entry_done), .rti(rti), .rti_x(rti_x), .rti_i(rti_i),
        .int_valid(int_valid), .int_kind(int_kind), .int_idx(int_idx),
        .x_mask(x_mask), .i_mask(i_mask)
    );

    // behavioural reference model
    bit m_s1 = 1, m_s2 = 1, m_x = 1, m_i = 1, m_pend = 0;
    int m_kind = 0, m_idx = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_x = 1; m_i = 1; m_pend = 0; m_kind = 0; m_idx = 0;
        end else begin
            bit lvl, tk, ox, oi;
            int k, ix;
            lvl = !m_s2; tk = m_pend && entry_done; ox = m_x; oi = m_i;
            if (tk) begin
                m_i = 1;
                if (m_kind == 2) m_x = 1;
            end else if (rti) begin
                m_x = rti_x; m_i = rti_i;
            end else if (ccr_wr) begin
                m_x = m_x && ccr_x; m_i = ccr_i;
            end
            if (!m_pend) begin
                if (boundary) begin
                    k = 0; ix = 0;
                    if (trap_req) k = 1;
                    else if (lvl && !ox) k = 2;
                    else if (irq_req != 0 && !oi) begin
                        k = 3;
                        for (int b = N - 1; b >= 0; b--) if (irq_req[b]) ix = b;
                    end
                    if (k != 0) begin m_pend = 1; m_kind = k; m_idx = ix; end
                end
            end else if (tk) begin
                m_pend = 0; m_kind = 0; m_idx = 0;
            end
            m_s2 = m_s1; m_s1 = nmi_n;
        end
    end

    task automatic chk(string req, string nm, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "int_valid", int_valid, m_pend);
            chk(cur_req, "int_kind", int_kind, m_kind);
            chk(cur_req, "int_idx", int_idx, m_idx);
            chk(cur_req, "x_mask", x_mask, m_x);
            chk(cur_req, "i_mask", i_mask, m_i);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        boundary = 0; entry_done = 0; rti = 0; ccr_wr = 0; trap_req = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "x_mask", x_mask, 1);
        chk("R1", "i_mask", i_mask, 1);
        chk("R1", "int_valid", int_valid, 0);
        rst_n = 1;
        tick();
        chk("R1", "x_mask after", x_mask, 1);
        chk("R1", "i_mask after", i_mask, 1);

        cur_req = "R5"; irq_req = 8'h24; boundary = 1; tick();
        chk("R5", "masked irq", int_valid, 0);

        cur_req = "R2"; ccr_wr = 1; ccr_x = 1; ccr_i = 0; tick();
        chk("R2", "x kept", x_mask, 1);
        chk("R2", "i written", i_mask, 0);

        cur_req = "R4"; boundary = 1; tick();
        chk("R4", "valid", int_valid, 1);
        chk("R4", "kind", int_kind, 3);
        chk("R4", "idx lowest", int_idx, 2);

        cur_req = "R6"; irq_req = 8'h01; boundary = 1; tick();
        chk("R6", "idx held", int_idx, 2);

        cur_req = "R7"; entry_done = 1; tick();
        chk("R7", "valid cleared", int_valid, 0);
        chk("R7", "i set", i_mask, 1);
        chk("R7", "x kept", x_mask, 1);

        cur_req = "R9"; rti = 1; rti_x = 1; rti_i = 0; tick();
        chk("R9", "i restored", i_mask, 0);

        cur_req = "R2"; ccr_wr = 1; ccr_x = 0; ccr_i = 1; tick();
        chk("R2", "x cleared", x_mask, 0);
        ccr_wr = 1; ccr_x = 1; ccr_i = 1; tick();
        chk("R2", "x set ignored", x_mask, 0);

        cur_req = "R3"; nmi_n = 0; boundary = 1; tick();
        chk("R3", "sync edge1", int_valid, 0);
        boundary = 1; tick();
        chk("R3", "sync edge2", int_valid, 0);
        boundary = 1; tick();
        chk("R3", "nmi with i set", int_valid, 1);
        chk("R3", "nmi kind", int_kind, 2);

        cur_req = "R8"; entry_done = 1; tick();
        chk("R8", "x set", x_mask, 1);
        chk("R8", "i set", i_mask, 1);

        cur_req = "R3"; boundary = 1; tick();
        chk("R3", "x gates nmi", int_valid, 0);

        cur_req = "R9"; rti = 1; rti_x = 0; rti_i = 0; tick();
        chk("R9", "x restored", x_mask, 0);

        cur_req = "R4"; trap_req = 1; boundary = 1; tick();
        chk("R4", "trap over nmi", int_kind, 1);
        cur_req = "R7"; entry_done = 1; tick();
        chk("R7", "trap sets i", i_mask, 1);
        chk("R7", "trap keeps x", x_mask, 0);

        cur_req = "R9"; rti = 1; rti_x = 1; rti_i = 1; tick();
        chk("R9", "x may be set", x_mask, 1);

        cur_req = "R10"; trap_req = 1; boundary = 1; tick();
        chk("R10", "trap masked ignored", int_kind, 1);
        entry_done = 1; tick();

        cur_req = "R4"; nmi_n = 1; rti = 1; rti_x = 0; rti_i = 0; tick();
        irq_req = 8'h90; tick(); tick();
        boundary = 1; tick();
        chk("R4", "idx 4", int_idx, 4);
        cur_req = "R11"; entry_done = 1; rti = 1; rti_x = 0; rti_i = 0; ccr_wr = 1; ccr_i = 0; tick();
        chk("R11", "entry wins i", i_mask, 1);
        chk("R11", "entry keeps x", x_mask, 0);
        irq_req = 8'h80; rti = 1; rti_x = 0; rti_i = 0; tick();
        boundary = 1; tick();
        chk("R4", "idx top", int_idx, 7);

        cur_req = "R11";
        for (int c = 0; c < 4000; c++) begin
            boundary   = ($urandom % 3) == 0;
            trap_req   = ($urandom % 16) == 0;
            irq_req    = (($urandom % 4) == 0) ? N'($urandom) : '0;
            if (($urandom % 20) == 0) nmi_n = ~nmi_n;
            entry_done = ($urandom % 4) == 0;
            rti        = ($urandom % 10) == 0;
            rti_x      = 1'($urandom);
            rti_i      = 1'($urandom);
            ccr_wr     = ($urandom % 8) == 0;
            ccr_x      = 1'($urandom);
            ccr_i      = 1'($urandom);
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule